// File: doc/BRIEF.md
# Serial-Command Power Authorization Controller

This block turns single-byte commands arriving on an asynchronous serial line into the power-up enable of a rider-carrying platform. A receiver for 8N1 frames (19200 baud at the default 50 MHz clock) recovers each byte. A three-state machine then decides whether the platform may be powered. One command code grants power. A second code withdraws it, but the withdrawal is gated by a rider-off flag, so the drive never goes dead under a standing rider.

The serial line is first passed through a two-flop synchronizer. The receiver finds each bit's centre by counting half a bit period from the start of the start bit. It rejects start pulses that are shorter than half a bit and discards frames whose stop bit is low. It also raises a one-cycle strobe for every byte it accepts.

The machine has three states, named here with their transitions:
- OFF: goes to PWR on the grant byte.
- PWR: goes to OFF on the withdraw byte when the rider is already off, and to PENDING_OFF on the withdraw byte while the rider is still on.
- PENDING_OFF: goes back to PWR on the grant byte, and goes to OFF when rider-off asserts.

The enable is high in PWR and in PENDING_OFF.

Top module: `power_auth_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `pwr_up` is 0 and `byte_valid` is 0; the machine starts in OFF.
- R2: A frame is one low start bit, 8 data bits sent LSB first, and one high stop bit, each lasting CLK_FREQ_HZ/BAUD clocks. Each correctly framed byte produces exactly one single-cycle pulse on `byte_valid`, during its stop bit.
- R3: Receiving 0x47 in OFF moves the machine to PWR and sets `pwr_up` to 1.
- R4: Receiving 0x53 in PWR while `rider_off` is 1 in the strobe cycle moves the machine straight to OFF, which clears `pwr_up`.
- R5: Receiving 0x53 in PWR while `rider_off` is 0 moves the machine to PENDING_OFF, and `pwr_up` stays 1.
- R6: In PENDING_OFF, `rider_off` at 1 with no grant byte in the same cycle moves the machine to OFF on the next edge, which clears `pwr_up`.
- R7: Receiving 0x47 in PENDING_OFF returns the machine to PWR. When the 0x47 strobe and `rider_off` coincide in the same cycle, the grant wins.
- R8: Every byte other than 0x47 and 0x53 leaves the state unchanged in every state. So do 0x47 in PWR, 0x53 in OFF, and 0x53 in PENDING_OFF while the rider is on.
- R9: A frame whose stop bit is sampled low gives no strobe and no state change. The receiver waits for the line to return high before it looks for a new start bit.
- R10: A low pulse on the line shorter than half a bit period is not taken as a start bit, so it gives no strobe.
- R11: `rider_off` has no effect in OFF or PWR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rider_off | input | 1 | Synchronous flag, high when no rider is detected |
| pwr_up | output | 1 | Power-up enable for the platform |
| byte_valid | output | 1 | One-cycle pulse per accepted byte |

## Verification
The two functions that can fall in the same cycle are the byte strobe carrying a command and the rider-off flag changing.

The bench provokes the collision by watching `byte_valid` during the stop bit and raising `rider_off` at the falling edge where the strobe is seen, so both reach the machine at the same rising edge. Two cases are provoked this way:
- A grant in PENDING_OFF must win and leave `pwr_up` high.
- A withdraw in PWR must take the direct path to OFF.

Outside the collision cases, an exhaustive sweep of all 256 byte values from every state is judged against an arithmetic model of the transitions.

// File: rtl/pa_pkg.sv
package pa_pkg;

    typedef enum logic [1:0] {
        PA_OFF  = 2'd0,
        PA_PWR  = 2'd1,
        PA_PEND = 2'd2
    } pa_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    localparam logic [7:0] CMD_GRANT    = 8'h47;
    localparam logic [7:0] CMD_WITHDRAW = 8'h53;

endpackage

// File: rtl/pa_sync.sv
module pa_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_in};
    end

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/pa_uart_rx.sv
module pa_uart_rx
    import pa_pkg::*;
#(
    parameter int CLKS_PER_BIT = 2604,
    parameter int DATA_BITS    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_s,
    output logic                 rx_vld,
    output logic [DATA_BITS-1:0] rx_data
);
    localparam int CW   = $clog2(CLKS_PER_BIT);
    localparam int BW   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam int HALF = CLKS_PER_BIT / 2;

    rx_state_e          st_q;
    logic [CW-1:0]      cnt_q;
    logic [BW-1:0]      idx_q;
    logic [DATA_BITS-1:0] sh_q;
    logic               vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RX_IDLE;
            cnt_q <= '0;
            idx_q <= '0;
            sh_q  <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            unique case (st_q)
                RX_IDLE: begin
                    cnt_q <= '0;
                    if (!rx_s) st_q <= RX_START;
                end
                RX_START: begin
                    if (cnt_q == CW'(HALF - 1)) begin
                        cnt_q <= '0;
                        idx_q <= '0;
                        st_q  <= rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt_q == CW'(CLKS_PER_BIT - 1)) begin
                        cnt_q <= '0;
                        sh_q  <= {rx_s, sh_q[DATA_BITS-1:1]};
                        if (idx_q == BW'(DATA_BITS - 1)) st_q <= RX_STOP;
                        else                             idx_q <= idx_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt_q == CW'(CLKS_PER_BIT - 1)) begin
                        cnt_q <= '0;
                        if (rx_s) begin
                            vld_q <= 1'b1;
                            st_q  <= RX_IDLE;
                        end else begin
                            st_q  <= RX_HOLD;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_HOLD: begin
                    if (rx_s) st_q <= RX_IDLE;
                end
                default: st_q <= RX_IDLE;
            endcase
        end
    end

    assign rx_vld  = vld_q;
    assign rx_data = sh_q;
endmodule

// File: rtl/pa_auth_fsm.sv
module pa_auth_fsm
    import pa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_vld,
    input  logic [7:0] cmd_byte,
    input  logic       rider_off,
    output logic       pwr_en,
    output logic [1:0] state_o
);
    pa_state_e state_q, state_d;
    logic      is_grant, is_withdraw;

    assign is_grant    = cmd_vld && (cmd_byte == CMD_GRANT);
    assign is_withdraw = cmd_vld && (cmd_byte == CMD_WITHDRAW);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PA_OFF: begin
                if (is_grant) state_d = PA_PWR;
            end
            PA_PWR: begin
                if (is_withdraw) state_d = rider_off ? PA_OFF : PA_PEND;
            end
            PA_PEND: begin
                if (is_grant)       state_d = PA_PWR;
                else if (rider_off) state_d = PA_OFF;
            end
            default: state_d = PA_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PA_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            PA_PWR, PA_PEND: pwr_en = 1'b1;
            default:         pwr_en = 1'b0;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/power_auth_ctrl.sv
module power_auth_ctrl #(
    parameter int CLK_FREQ_HZ = 50_000_000,
    parameter int BAUD        = 19200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_line,
    input  logic rider_off,
    output logic pwr_up,
    output logic byte_valid
);
    localparam int CLKS_PER_BIT = CLK_FREQ_HZ / BAUD;

    logic       rx_s;
    logic       rx_vld;
    logic [7:0] rx_data;
    logic [1:0] auth_state;

    pa_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rx_line),
        .q_out (rx_s)
    );

    pa_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(8)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_s    (rx_s),
        .rx_vld  (rx_vld),
        .rx_data (rx_data)
    );

    pa_auth_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_vld   (rx_vld),
        .cmd_byte  (rx_data),
        .rider_off (rider_off),
        .pwr_en    (pwr_up),
        .state_o   (auth_state)
    );

    assign byte_valid = rx_vld;
endmodule

// File: rtl/power_auth_chk.sv
module power_auth_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rider_off,
    input logic       pwr_up,
    input logic       byte_valid,
    input logic [1:0] fsm_state
);
    import pa_pkg::*;

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    assert_rise_after_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_up) |-> $past(byte_valid));

    assert_fall_needs_rider_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_up) |-> $past(rider_off));

    assert_pending_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == PA_PEND && rider_off && !byte_valid) |=> (fsm_state == PA_OFF));

    assert_off_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == PA_OFF && !byte_valid) |=> (fsm_state == PA_OFF));

    assert_state_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state != 2'd3);
endmodule

bind power_auth_ctrl power_auth_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rider_off  (rider_off),
    .pwr_up     (pwr_up),
    .byte_valid (byte_valid),
    .fsm_state  (auth_state)
);

// File: tb/test_power_auth_ctrl.sv
`timescale 1ns/1ps
module test_power_auth_ctrl;
    localparam int BIT = 6;
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_line = 1'b1;
    logic rider_off = 1'b0;
    logic pwr_up, byte_valid;

    int checks = 0;
    int failures = 0;
    int strobes = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    power_auth_ctrl #(.CLK_FREQ_HZ(BIT * 19200), .BAUD(19200)) i_power_auth_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rider_off(rider_off),
        .pwr_up(pwr_up), .byte_valid(byte_valid)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && byte_valid) strobes <= strobes + 1;
    end

    always @(posedge clk) begin
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired: cycles=%0d expected<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit ro);
        rst_n = 1'b0;
        rx_line = 1'b1;
        rider_off = ro;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Sends one frame; optionally raises rider_off in the cycle the strobe is seen.
    task automatic send_byte(input logic [7:0] v, input bit stop_ok, input bit ro_at_strobe);
        rx_line = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = v[i];
            repeat (BIT) @(negedge clk);
        end
        rx_line = stop_ok;
        for (int k = 0; k < BIT; k++) begin
            @(negedge clk);
            if (ro_at_strobe && byte_valid) rider_off = 1'b1;
        end
        rx_line = 1'b1;
        repeat (BIT) @(negedge clk);
    endtask

    // State codes for the model: 0 OFF, 1 PWR, 2 PENDING_OFF.
    function automatic int model(input int st, input logic [7:0] v, input bit ro);
        int n = st;
        case (st)
            0: if (v == 8'h47) n = 1;
            1: if (v == 8'h53) n = ro ? 0 : 2;
            2: if (v == 8'h47) n = 1; else if (ro) n = 0;
            default: n = 0;
        endcase
        return n;
    endfunction

    task automatic reach(input int st, input bit ro);
        do_reset(1'b0);
        if (st >= 1) send_byte(8'h47, 1'b1, 1'b0);
        if (st == 2) send_byte(8'h53, 1'b1, 1'b0);
        rider_off = ro;
        @(negedge clk);
    endtask

    initial begin
        int s0;
        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(pwr_up == 1'b0, "R1 pwr_up in reset", pwr_up, 0);
        check(byte_valid == 1'b0, "R1 byte_valid in reset", byte_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pwr_up == 1'b0, "R1 pwr_up after reset", pwr_up, 0);

        // R3 / R5 / R6 directed path
        s0 = strobes;
        send_byte(8'h47, 1'b1, 1'b0);
        check(strobes - s0 == 1, "R2 one strobe per frame", strobes - s0, 1);
        check(pwr_up == 1'b1, "R3 grant from OFF", pwr_up, 1);
        send_byte(8'h53, 1'b1, 1'b0);
        check(pwr_up == 1'b1, "R5 withdraw with rider on holds power", pwr_up, 1);
        repeat (20) @(negedge clk);
        check(pwr_up == 1'b1, "R5 pending keeps power", pwr_up, 1);
        rider_off = 1'b1;
        check(pwr_up == 1'b1, "R6 before edge", pwr_up, 1);
        @(negedge clk);
        check(pwr_up == 1'b0, "R6 rider steps off in pending", pwr_up, 0);

        // R11: rider_off ignored in OFF and PWR
        do_reset(1'b0);
        rider_off = 1'b1;
        repeat (10) @(negedge clk);
        check(pwr_up == 1'b0, "R11 rider_off in OFF", pwr_up, 0);
        rider_off = 1'b0;
        send_byte(8'h47, 1'b1, 1'b0);
        rider_off = 1'b1;
        repeat (10) @(negedge clk);
        rider_off = 1'b0;
        repeat (10) @(negedge clk);
        check(pwr_up == 1'b1, "R11 rider_off toggle in PWR", pwr_up, 1);

        // R7 collision: grant strobe and rider_off in the same cycle in PENDING_OFF
        reach(2, 1'b0);
        send_byte(8'h47, 1'b1, 1'b1);
        check(rider_off == 1'b1, "R7 collision provoked", rider_off, 1);
        check(pwr_up == 1'b1, "R7 grant wins over rider_off", pwr_up, 1);
        repeat (10) @(negedge clk);
        check(pwr_up == 1'b1, "R7 back in PWR ignores rider_off", pwr_up, 1);

        // R4 collision: withdraw strobe and rider_off in the same cycle in PWR
        reach(1, 1'b0);
        send_byte(8'h53, 1'b1, 1'b1);
        check(pwr_up == 1'b0, "R4 withdraw with rider_off same cycle", pwr_up, 0);

        // R9: framing error
        reach(1, 1'b0);
        s0 = strobes;
        send_byte(8'h53, 1'b0, 1'b0);
        check(strobes - s0 == 0, "R9 no strobe on bad stop", strobes - s0, 0);
        check(pwr_up == 1'b1, "R9 no state change on bad stop", pwr_up, 1);
        repeat (BIT * 2) @(negedge clk);
        s0 = strobes;
        send_byte(8'h53, 1'b1, 1'b0);
        check(strobes - s0 == 1, "R9 receiver recovers", strobes - s0, 1);

        // R10: short glitch
        reach(0, 1'b0);
        s0 = strobes;
        rx_line = 1'b0;
        @(negedge clk);
        rx_line = 1'b1;
        repeat (BIT * 12) @(negedge clk);
        check(strobes - s0 == 0, "R10 glitch rejected", strobes - s0, 0);
        check(pwr_up == 1'b0, "R10 glitch no state change", pwr_up, 0);

        // R2 / R8: exhaustive sweep of byte values from every state
        for (int st = 0; st < 4; st++) begin
            for (int v = 0; v < 256; v++) begin
                int sst = (st == 3) ? 1 : st;
                bit ro = (st == 3);
                int exp;
                reach(sst, ro);
                s0 = strobes;
                send_byte(v[7:0], 1'b1, 1'b0);
                exp = model(sst, v[7:0], ro);
                check(strobes - s0 == 1, "R2 sweep strobe count", strobes - s0, 1);
                check(pwr_up == (exp != 0), "R8 sweep pwr_up", pwr_up, (exp != 0));
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule